// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block is a bus master that loads a configuration image into a programmable device over its slave-serial port. It drives the target's active-low reset, its select line, a serial clock and a serial data line, and it reads the target's configuration-complete flag. The image is a series of 32-bit words pulled from a word-addressed read port with one cycle of read latency. The block prefetches the next word while the current word is still shifting out, so the serial stream has no gaps between words.

A host pulses `start_i` with a mode bit, a clock divider and a completion timeout. In plain mode the target is clocked 32 times while held in reset and 32 more times after reset is released. In low-power mode the target is released from reset after a short pulse and given a long settling wait. The block then issues a fixed preamble of command bytes, with counted select-high idle gaps between the groups. After the image, a trailer of flush clocks is sent and the done flag is sampled. The block reports done, or reports fail if the flag stays low for the whole timeout window.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, and while idle, the outputs are: select high, target reset high (released), serial clock high, data low, busy low, done low, fail low.
- R2: A start pulse while idle raises busy in the next cycle and latches the mode, divider and timeout. A start pulse while busy is ignored and leaves the running sequence unchanged.
- R3: Every sequence begins with select low and the target reset low for at least RST_LOW_CYC system cycles. The target reset is never low while select is high.
- R4: In plain mode (`lowpwr_i`=0), the target sees 32 serial clocks with reset low, then 32 clocks with reset released, all with select and data low. The image follows directly.
- R5: In low-power mode (`lowpwr_i`=1), the target reset is released and at least RST_WAIT_CYC system cycles pass before the first falling edge of the serial clock.
- R6: The low-power preamble, counted in rising serial edges, is: 8 select-high clocks; the bytes 7E AA 99 7E 01 0E; LONG_IDLE (default 13000) select-high clocks; 83 00 00 26 11; 8 select-high clocks; 83 00 00 27 21; 8 select-high clocks; 81; 8 select-high clocks. Bytes are sent with select low. Data is low during select-high clocks.
- R7: Bytes and words are shifted most-significant bit first. Data, select and target reset change only while the serial clock is low, so each bit is stable at its rising edge.
- R8: The image is WORDS 32-bit words read from addresses 0 to WORDS-1 in order, with exactly one read strobe per word. Read data is taken one cycle after the strobe. Select is low while the image is sent.
- R9: While clocking, the serial clock period is 2*(div_i+1) system cycles.
- R10: After the last image bit the block gives 25 clocks with select and data low, then 25 clocks with select high and data low.
- R11: After the trailer, the done flag is sampled once per extra serial clock. The first high sample ends the sequence with done_o. If timeout_i+1 samples are all low, the sequence ends with fail_o. Done and fail are never high together.
- R12: When a sequence ends, busy falls, the serial clock parks high, select stays high, and done/fail hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| lowpwr_i | input | 1 | 1 selects the low-power preamble, 0 the plain reset clocking |
| div_i | input | DIV_W | Serial half-period minus one, in system cycles |
| timeout_i | input | TO_W | Extra done-flag samples allowed after the first |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence saw the done flag |
| fail_o | output | 1 | Last sequence timed out |
| word_rd_o | output | 1 | Image word read strobe |
| word_addr_o | output | AW | Image word address |
| word_data_i | input | 32 | Image word, valid one cycle after the strobe |
| tgt_rst_no | output | 1 | Target reset, active low |
| tgt_sel_o | output | 1 | Target select |
| tgt_sck_o | output | 1 | Target serial clock, idles high |
| tgt_sdo_o | output | 1 | Target serial data |
| tgt_done_i | input | 1 | Target configuration-complete flag |

## Verification
The hardest situation to reach from the ports is the full low-power preamble. Its 13000-clock select-high gap sits between short byte groups, and a miscount of one clock or one bit at any group boundary must be caught. The bench records select, data and target reset at every rising serial edge. It compares that record against an expected stream built from the byte list and idle counts. It repeats this at two divider settings, with both done outcomes, and with a second start pulse with different settings injected mid-run.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LOW, S_RST_CLK, S_REL_CLK, S_WAIT,
    S_PRE_IDLE, S_PRE_BYTE, S_IMAGE, S_FLUSH_LO, S_FLUSH_HI, S_CHECK
  } ld_state_e;

  localparam int RST_CLKS   = 32;
  localparam int FLUSH_CLKS = 25;
  localparam int SHORT_IDLE = 8;
  localparam int NUM_GRP    = 4;

  function automatic logic [7:0] pre_byte(input logic [4:0] idx);
    case (idx)
      5'd0:  pre_byte = 8'h7E;
      5'd1:  pre_byte = 8'hAA;
      5'd2:  pre_byte = 8'h99;
      5'd3:  pre_byte = 8'h7E;
      5'd4:  pre_byte = 8'h01;
      5'd5:  pre_byte = 8'h0E;
      5'd6:  pre_byte = 8'h83;
      5'd9:  pre_byte = 8'h26;
      5'd10: pre_byte = 8'h11;
      5'd11: pre_byte = 8'h83;
      5'd14: pre_byte = 8'h27;
      5'd15: pre_byte = 8'h21;
      5'd16: pre_byte = 8'h81;
      default: pre_byte = 8'h00;
    endcase
  endfunction

  // index of the last byte in each preamble group
  function automatic logic [4:0] grp_last(input logic [2:0] g);
    case (g)
      3'd0: grp_last = 5'd5;
      3'd1: grp_last = 5'd10;
      3'd2: grp_last = 5'd15;
      default: grp_last = 5'd16;
    endcase
  endfunction

  // select-high gap preceding byte group g (g == NUM_GRP is the final gap)
  function automatic int unsigned idle_len(input logic [2:0] g, input int unsigned long_idle);
    idle_len = (g == 3'd1) ? long_idle : SHORT_IDLE;
  endfunction

endpackage

// File: rtl/cfg_sck_gen.sv
module cfg_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign fall_o = en_i && wrap && sck_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R12
  sck_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sck_o);

endmodule

// File: rtl/cfg_word_fetch.sv
module cfg_word_fetch #(
  parameter int WORDS = 4,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          take_i,
  output logic          rd_o,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] word_o
);

  localparam logic [AW-1:0] LIMIT = AW'(WORDS);

  logic          rd_q, pend_q, valid_q;
  logic [AW-1:0] addr_q, nxt_q;
  logic [DW-1:0] word_q;

  assign rd_o   = rd_q;
  assign addr_o = addr_q;
  assign word_o = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      nxt_q   <= '0;
      word_q  <= '0;
    end else begin
      pend_q <= rd_q;
      rd_q   <= 1'b0;
      if (pend_q) begin
        word_q  <= data_i;
        valid_q <= 1'b1;
      end
      if (restart_i) begin
        rd_q    <= 1'b1;
        addr_q  <= '0;
        nxt_q   <= AW'(1);
        valid_q <= 1'b0;
      end else if (take_i) begin
        valid_q <= 1'b0;
        if (nxt_q != LIMIT) begin
          rd_q   <= 1'b1;
          addr_q <= nxt_q;
          nxt_q  <= nxt_q + 1'b1;
        end
      end
    end
  end

  // R8
  take_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> valid_q);

  // R8
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (addr_o < LIMIT));

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_load_pkg::*;
#(
  parameter int WORDS        = 17022,
  parameter int DIV_W        = 8,
  parameter int TO_W         = 16,
  parameter int RST_LOW_CYC  = 32,
  parameter int RST_WAIT_CYC = 40000,
  parameter int LONG_IDLE    = 13000,
  localparam int AW          = $clog2(WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             lowpwr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             word_rd_o,
  output logic [AW-1:0]    word_addr_o,
  input  logic [31:0]      word_data_i,
  output logic             tgt_rst_no,
  output logic             tgt_sel_o,
  output logic             tgt_sck_o,
  output logic             tgt_sdo_o,
  input  logic             tgt_done_i
);

  localparam int WAIT_MAX = (RST_LOW_CYC > RST_WAIT_CYC) ? RST_LOW_CYC : RST_WAIT_CYC;
  localparam int CW       = $clog2(WAIT_MAX + 1);
  localparam int LW0      = $clog2(LONG_IDLE + 1);
  localparam int LW       = (LW0 > 6) ? LW0 : 6;

  localparam logic [CW-1:0] LOW_LAST   = CW'(RST_LOW_CYC - 1);
  localparam logic [CW-1:0] WAIT_LAST  = CW'(RST_WAIT_CYC - 1);
  localparam logic [LW-1:0] RST_LAST   = LW'(RST_CLKS - 1);
  localparam logic [LW-1:0] FLUSH_LAST = LW'(FLUSH_CLKS - 1);
  localparam logic [AW-1:0] WORD_LAST  = AW'(WORDS - 1);

  ld_state_e        state;
  logic             lp_q;
  logic [DIV_W-1:0] div_q;
  logic [TO_W-1:0]  to_q, extra_q;
  logic [CW-1:0]    cyc_q;
  logic [LW-1:0]    clk_q;
  logic [4:0]       bit_q, bidx_q;
  logic [2:0]       grp_q;
  logic [AW-1:0]    wcnt_q;
  logic [31:0]      sreg_q;
  logic             sel_q, rstn_q, sdo_q, busy_q, done_q, fail_q;
  logic [1:0]       done_s;

  logic             sck_en, fall, go, take;
  logic [31:0]      buf_word;
  logic [7:0]       cur_byte;

  assign go       = (state == S_IDLE) && start_i;
  assign take     = fall && (state == S_IMAGE) && (bit_q == 5'd0);
  assign cur_byte = pre_byte(bidx_q);
  assign sck_en   = !(state inside {S_IDLE, S_RST_LOW, S_WAIT});

  cfg_sck_gen #(.DIV_W(DIV_W)) i_sck_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sck_en),
    .div_i  (div_q),
    .sck_o  (tgt_sck_o),
    .fall_o (fall)
  );

  cfg_word_fetch #(.WORDS(WORDS), .AW(AW), .DW(32)) i_word_fetch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (go),
    .take_i    (take),
    .rd_o      (word_rd_o),
    .addr_o    (word_addr_o),
    .data_i    (word_data_i),
    .word_o    (buf_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_s <= '0;
    else         done_s <= {done_s[0], tgt_done_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= S_IDLE;
      lp_q    <= 1'b0;
      div_q   <= '0;
      to_q    <= '0;
      extra_q <= '0;
      cyc_q   <= '0;
      clk_q   <= '0;
      bit_q   <= '0;
      bidx_q  <= '0;
      grp_q   <= '0;
      wcnt_q  <= '0;
      sreg_q  <= '0;
      sel_q   <= 1'b1;
      rstn_q  <= 1'b1;
      sdo_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start_i) begin
          lp_q   <= lowpwr_i;
          div_q  <= div_i;
          to_q   <= timeout_i;
          busy_q <= 1'b1;
          done_q <= 1'b0;
          fail_q <= 1'b0;
          sel_q  <= 1'b0;
          rstn_q <= 1'b0;
          sdo_q  <= 1'b0;
          cyc_q  <= '0;
          state  <= S_RST_LOW;
        end
        S_RST_LOW: begin
          if (cyc_q == LOW_LAST) begin
            cyc_q <= '0;
            clk_q <= '0;
            if (lp_q) begin
              rstn_q <= 1'b1;
              state  <= S_WAIT;
            end else begin
              state <= S_RST_CLK;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        S_WAIT: begin
          if (cyc_q == WAIT_LAST) begin
            clk_q  <= '0;
            grp_q  <= '0;
            bidx_q <= '0;
            state  <= S_PRE_IDLE;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        S_RST_CLK: if (fall) begin
          if (clk_q == RST_LAST) begin
            clk_q <= '0;
            state <= S_REL_CLK;
          end else clk_q <= clk_q + 1'b1;
        end
        S_REL_CLK: if (fall) begin
          rstn_q <= 1'b1;
          if (clk_q == RST_LAST) begin
            bit_q  <= '0;
            wcnt_q <= '0;
            state  <= S_IMAGE;
          end else clk_q <= clk_q + 1'b1;
        end
        S_PRE_IDLE: if (fall) begin
          sel_q <= 1'b1;
          sdo_q <= 1'b0;
          if (clk_q == LW'(idle_len(grp_q, LONG_IDLE) - 1)) begin
            clk_q <= '0;
            bit_q <= '0;
            if (grp_q == 3'(NUM_GRP)) begin
              wcnt_q <= '0;
              state  <= S_IMAGE;
            end else begin
              state <= S_PRE_BYTE;
            end
          end else clk_q <= clk_q + 1'b1;
        end
        S_PRE_BYTE: if (fall) begin
          sel_q <= 1'b0;
          sdo_q <= cur_byte[~bit_q[2:0]];
          if (bit_q == 5'd7) begin
            bit_q  <= '0;
            bidx_q <= bidx_q + 1'b1;
            if (bidx_q == grp_last(grp_q)) begin
              grp_q <= grp_q + 1'b1;
              clk_q <= '0;
              state <= S_PRE_IDLE;
            end
          end else bit_q <= bit_q + 1'b1;
        end
        S_IMAGE: if (fall) begin
          sel_q <= 1'b0;
          if (bit_q == 5'd0) begin
            sdo_q  <= buf_word[31];
            sreg_q <= {buf_word[30:0], 1'b0};
          end else begin
            sdo_q  <= sreg_q[31];
            sreg_q <= {sreg_q[30:0], 1'b0};
          end
          bit_q <= bit_q + 1'b1;
          if (bit_q == 5'd31) begin
            if (wcnt_q == WORD_LAST) begin
              clk_q <= '0;
              state <= S_FLUSH_LO;
            end else wcnt_q <= wcnt_q + 1'b1;
          end
        end
        S_FLUSH_LO: if (fall) begin
          sel_q <= 1'b0;
          sdo_q <= 1'b0;
          if (clk_q == FLUSH_LAST) begin
            clk_q <= '0;
            state <= S_FLUSH_HI;
          end else clk_q <= clk_q + 1'b1;
        end
        S_FLUSH_HI: if (fall) begin
          sel_q <= 1'b1;
          sdo_q <= 1'b0;
          if (clk_q == FLUSH_LAST) begin
            extra_q <= '0;
            state   <= S_CHECK;
          end else clk_q <= clk_q + 1'b1;
        end
        S_CHECK: if (fall) begin
          if (done_s[1]) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            state  <= S_IDLE;
          end else if (extra_q == to_q) begin
            fail_q <= 1'b1;
            busy_q <= 1'b0;
            state  <= S_IDLE;
          end else extra_q <= extra_q + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;
  assign tgt_sel_o  = sel_q;
  assign tgt_rst_no = rstn_q;
  assign tgt_sdo_o  = sdo_q;

  // R7
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_en && $past(sck_en) && tgt_sck_o && $past(tgt_sck_o)
    |-> $stable(tgt_sdo_o) && $stable(tgt_sel_o) && $stable(tgt_rst_no));

  // R11
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_o, fail_o}) <= 1);

  // R2
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o && !fail_o);

  // R3
  rst_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_rst_no |-> !tgt_sel_o);

  // R12
  idle_sck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !$past(busy_o) |-> tgt_sck_o);

endmodule

// File: tb/test_cfg_stream_loader.sv
module test_cfg_stream_loader;

  localparam int WORDS     = 4;
  localparam int DIV_W     = 8;
  localparam int TO_W      = 16;
  localparam int RST_LOW   = 20;
  localparam int RST_WAIT  = 100;
  localparam int LONG_IDLE = 13000;
  localparam int AW        = $clog2(WORDS + 1);

  typedef struct packed {
    logic        lp;
    logic [7:0]  div;
    logic [7:0]  to;
    logic        dn;
    logic [31:0] seed;
  } case_t;

  localparam case_t CASES [6] = '{
    '{1'b0, 8'd0, 8'd3, 1'b1, 32'h1234_5678},
    '{1'b0, 8'd3, 8'd2, 1'b0, 32'hA5C3_0F96},
    '{1'b1, 8'd0, 8'd0, 1'b1, 32'hDEAD_BEEF},
    '{1'b0, 8'd1, 8'd0, 1'b0, 32'h0F0F_F0F0},
    '{1'b1, 8'd1, 8'd4, 1'b0, 32'h8001_7FFE},
    '{1'b0, 8'd7, 8'd1, 1'b1, 32'h5555_AAAA}
  };

  // preamble bytes and group layout, per R6
  localparam logic [7:0] PRE [17] = '{8'h7E, 8'hAA, 8'h99, 8'h7E, 8'h01, 8'h0E,
    8'h83, 8'h00, 8'h00, 8'h26, 8'h11, 8'h83, 8'h00, 8'h00, 8'h27, 8'h21, 8'h81};
  localparam int GRP_FIRST [4] = '{0, 6, 11, 16};
  localparam int GRP_END   [4] = '{5, 10, 15, 16};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, lowpwr = 1'b0, tgt_done = 1'b0;
  logic [DIV_W-1:0] div_in = '0;
  logic [TO_W-1:0]  tmo = '0;
  logic busy, done, fail, word_rd, sel, rstn, sck, sdo;
  logic [AW-1:0] word_addr;
  logic [31:0]   word_data = '0;

  always #4 clk = ~clk;

  cfg_stream_loader #(
    .WORDS(WORDS), .DIV_W(DIV_W), .TO_W(TO_W), .RST_LOW_CYC(RST_LOW),
    .RST_WAIT_CYC(RST_WAIT), .LONG_IDLE(LONG_IDLE)
  ) i_cfg_stream_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lowpwr_i(lowpwr),
    .div_i(div_in), .timeout_i(tmo), .busy_o(busy), .done_o(done), .fail_o(fail),
    .word_rd_o(word_rd), .word_addr_o(word_addr), .word_data_i(word_data),
    .tgt_rst_no(rstn), .tgt_sel_o(sel), .tgt_sck_o(sck), .tgt_sdo_o(sdo),
    .tgt_done_i(tgt_done)
  );

  int nchk = 0, nerr = 0;
  logic [31:0] seed = '0;
  int rd_cnt = 0;

  function automatic logic [31:0] pat(input int a, input logic [31:0] s);
    if (a == 0) return 32'h7EAA_997E;
    return (s ^ (32'(a) * 32'h0100_0193)) + 32'(a);
  endfunction

  // image memory, one cycle of read latency
  always @(posedge clk) begin
    if (word_rd) begin
      word_data <= pat(int'(word_addr), seed);
      rd_cnt = rd_cnt + 1;
    end
  end

  // serial stream monitor: {sel, sdo, rst_n} at every rising serial edge
  logic [2:0] exp_q [$];
  bit     mon_on = 1'b0;
  int     rise_n = 0, mism = 0, bad_idx = -1;
  logic [2:0] bad_got = '0;
  time    t_r2 = 0, t_r3 = 0, t_rf = 0, t_rr = 0, t_ff = 0;
  bit     got_ff = 1'b0;
  logic   sel_at_rf = 1'b1;

  always @(posedge sck) begin
    if (mon_on) begin
      if (rise_n >= exp_q.size() || {sel, sdo, rstn} != exp_q[rise_n]) begin
        if (mism == 0) begin
          bad_idx = rise_n;
          bad_got = {sel, sdo, rstn};
        end
        mism = mism + 1;
      end
      if (rise_n == 2) t_r2 = $time;
      if (rise_n == 3) t_r3 = $time;
      rise_n = rise_n + 1;
    end
  end

  always @(negedge rstn) if (mon_on) begin
    t_rf = $time;
    #1 sel_at_rf = sel;
  end
  always @(posedge rstn) if (mon_on) t_rr = $time;
  always @(negedge sck) if (mon_on && !got_ff) begin
    t_ff = $time;
    got_ff = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_n(input int n, input logic s, input logic d, input logic r);
    for (int i = 0; i < n; i++) exp_q.push_back({s, d, r});
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back({1'b0, b[i], 1'b1});
  endtask

  task automatic build(input bit lp, input int to, input bit dn, input logic [31:0] sd);
    exp_q.delete();
    if (lp) begin
      push_n(8, 1'b1, 1'b0, 1'b1);
      for (int g = 0; g < 4; g++) begin
        for (int k = GRP_FIRST[g]; k <= GRP_END[g]; k++) push_byte(PRE[k]);
        push_n((g == 0) ? LONG_IDLE : 8, 1'b1, 1'b0, 1'b1);
      end
    end else begin
      push_n(32, 1'b0, 1'b0, 1'b0);
      push_n(32, 1'b0, 1'b0, 1'b1);
    end
    for (int w = 0; w < WORDS; w++) begin
      logic [31:0] v;
      v = pat(w, sd);
      for (int i = 31; i >= 0; i--) exp_q.push_back({1'b0, v[i], 1'b1});
    end
    push_n(25, 1'b0, 1'b0, 1'b1);
    push_n(25, 1'b1, 1'b0, 1'b1);
    push_n(dn ? 1 : to + 1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic run_case(input bit lp, input int dv, input int to, input bit dn,
                          input logic [31:0] sd, input bit poke);
    int n;
    build(lp, to, dn, sd);
    seed = sd;
    tgt_done = dn;
    rise_n = 0; mism = 0; bad_idx = -1; rd_cnt = 0;
    t_r2 = 0; t_r3 = 0; t_rf = 0; t_rr = 0; t_ff = 0; got_ff = 1'b0; sel_at_rf = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1; lowpwr = lp; div_in = DIV_W'(dv); tmo = TO_W'(to);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    n = 0;
    while (busy && n < 150000) begin
      @(negedge clk);
      n++;
      if (poke && n == 300) begin
        start = 1'b1; lowpwr = !lp; div_in = DIV_W'(dv + 2); tmo = '0;
      end else start = 1'b0;
    end
    chk(!busy, "R11", "sequence ended", busy, 0);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    chk(mism == 0 && rise_n == exp_q.size(), lp ? "R6 R7 R8 R10" : "R4 R7 R8 R10",
        poke ? "stream with start ignored (R2)" : "serial stream",
        (mism == 0) ? rise_n : bad_idx, (mism == 0) ? exp_q.size() : -1);
    if (mism != 0)
      chk(1'b0, "R7", "first mismatching {sel,sdo,rst}", bad_got, exp_q[bad_idx]);
    chk(done == dn, "R11", "done_o", done, dn);
    chk(fail == !dn, "R11", "fail_o", fail, !dn);
    chk(rd_cnt == WORDS, "R8", "word reads", rd_cnt, WORDS);
    chk((t_r3 - t_r2) == time'(2 * (dv + 1) * 8), "R9", "serial period ns",
        t_r3 - t_r2, 2 * (dv + 1) * 8);
    chk((t_rr - t_rf) >= time'(RST_LOW * 8) && sel_at_rf == 1'b0, "R3",
        "reset low ns", t_rr - t_rf, RST_LOW * 8);
    if (lp)
      chk(got_ff && (t_ff - t_rr) >= time'(RST_WAIT * 8), "R5", "release to first fall ns",
          t_ff - t_rr, RST_WAIT * 8);
    chk({sck, sel, rstn, busy} == 4'b1110, "R12", "parked {sck,sel,rst,busy}",
        {sck, sel, rstn, busy}, 4'b1110);
  endtask

  initial begin
    #(190000 * 8);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sel, rstn, sck, sdo, busy, done, fail} == 7'b1110000, "R1", "idle outputs",
        {sel, rstn, sck, sdo, busy, done, fail}, 7'b1110000);

    for (int c = 0; c < 6; c++)
      run_case(CASES[c].lp, int'(CASES[c].div), int'(CASES[c].to), CASES[c].dn,
               CASES[c].seed, 1'b0);

    // R2 second start while busy, with other settings, must be ignored
    run_case(1'b0, 0, 2, 1'b1, 32'h3C3C_C3C3, 1'b1);

    // R1 asynchronous reset in mid-sequence returns to idle
    @(negedge clk);
    start = 1'b1; lowpwr = 1'b0; div_in = '0; tmo = '0; tgt_done = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({sel, rstn, sck, sdo, busy, done, fail} == 7'b1110000, "R1", "outputs in reset",
        {sel, rstn, sck, sdo, busy, done, fail}, 7'b1110000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({sel, rstn, sck, busy} == 4'b1110, "R1", "idle after reset",
        {sel, rstn, sck, busy}, 4'b1110);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule